// File: doc/BRIEF.md
# Flash Bank Erase and Program Sequencer

This block models one on-chip flash bank as a register array and sequences the two operations that change it. A bank erase is not a single step. It first forces every word to zero, then forces every word to one, and finally holds for a settling (equalize) interval that leaves the contents unchanged. Phases 1 and 2 each touch one word per clock. A single-word program can only clear bits: the stored word becomes the bitwise AND of the old word and the new data.

A sticky erase-complete flag is set only when the equalize interval finishes. A program command is refused unless this flag is set. An abort input models a reset or a loss of supply during an operation. It returns the sequencer to idle at once and leaves the array exactly as far as the sequence had reached. Status outputs give busy, done and three error bits. A registered read port returns any word.

Top module: `flash_bank_seq`

## Requirements
- R1: After reset the block is idle, with busy, done, eraseOk and all three error bits low, and every word reads as all ones.
- R2: An erase accepted while idle keeps busy high for exactly 2*WORDS+EQ_CYCLES cycles. It then raises done and eraseOk together, and every word reads all ones.
- R3: Phase 1 clears word 0 first and then one ascending word per cycle. An abort after k clearing cycles leaves words 0..k-1 at zero and the other words at their prior contents.
- R4: Phase 2 sets word 0 first and then one ascending word per cycle. An abort after k setting cycles leaves words 0..k-1 at all ones and the other words at zero.
- R5: When abortReq is high at a clock edge, busy, done and eraseOk are low after that edge. No array write occurs on that edge. An abort during the equalize interval leaves all words at all ones.
- R6: A program command (cmdProg=1) issued while eraseOk is low sets errNotErased. It leaves the word unchanged, does not raise busy and does not raise done.
- R7: A program command whose data clears bits (the new data has no 1 where the stored word has 0) is legal. It is busy for one cycle, then stores old AND data and raises done.
- R8: A program command whose data has a 1 where the stored word has a 0 sets errBitUp. It leaves the word unchanged and raises neither busy nor done.
- R9: A command presented while busy is ignored and sets errOverrun. All error bits clear on the next command accepted while idle.
- R10: Accepting an erase command (cmdProg=0) clears eraseOk immediately, so eraseOk is low while the erase runs.
- R11: rdData presents the word at rdAddr one clock after rdAddr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdProg | input | 1 | 1 = program one word, 0 = erase bank |
| cmdAddr | input | $clog2(WORDS) | Word address for program |
| cmdData | input | DATA_W | Program data |
| abortReq | input | 1 | Interrupts any operation at the next edge |
| rdAddr | input | $clog2(WORDS) | Read address |
| rdData | output | DATA_W | Registered read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished normally |
| eraseOk | output | 1 | Sticky: an erase ran through equalize |
| errOverrun | output | 1 | A command arrived while busy |
| errBitUp | output | 1 | A program would have set a cleared bit |
| errNotErased | output | 1 | A program was refused before a complete erase |

## Verification
A wrong word counter shows up at the ports as a busy window of the wrong length. It also puts the boundary between zeroed, set and untouched words in the wrong place after an abort, and a full read-back reveals this within one read per word. A phase state that is stuck or skipped shows as eraseOk rising too early or never. It also shows as words left at zero after a completed erase. A broken program gate shows on the same cycle as errNotErased or errBitUp missing. It shows one cycle later as a stored word that differs from the AND of old and new data.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLR,
    S_SET,
    S_EQ,
    S_PROG
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture program address and data
    logic cntClr;  // restart the word counter
    logic cntInc;  // advance the word counter
    logic wrZero;  // clear word at counter
    logic wrOne;   // set word at counter
    logic wrProg;  // AND latched data into latched word
  } seq_strobe_t;

endpackage

// File: rtl/flash_seq_dpath.sv
module flash_seq_dpath
  import flash_seq_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic [AW-1:0]     cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              cntLast,
  output logic              progLegal
);

  localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [AW-1:0]     wordCnt;
  logic [AW-1:0]     progAddr;
  logic [DATA_W-1:0] progData;

  assign cntLast   = (wordCnt == LAST_IDX);
  // legal when no new 1 lands on a stored 0
  assign progLegal = ((~mem[cmdAddr] & cmdData) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt  <= '0;
      progAddr <= '0;
      progData <= '0;
    end else begin
      if (strb.cntClr || (strb.cntInc && cntLast)) wordCnt <= '0;
      else if (strb.cntInc)                         wordCnt <= wordCnt + 1'b1;
      if (strb.latch) begin
        progAddr <= cmdAddr;
        progData <= cmdData;
      end
    end
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN)                                             mem[w] <= '1;
        else if (strb.wrZero && wordCnt == AW'(w))             mem[w] <= '0;
        else if (strb.wrOne && wordCnt == AW'(w))              mem[w] <= '1;
        else if (strb.wrProg && progAddr == AW'(w))            mem[w] <= mem[w] & progData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int EQ_CYCLES = 16,
  localparam int EW       = $clog2(EQ_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdProg,
  input  logic        abortReq,
  input  logic        cntLast,
  input  logic        progLegal,
  output seq_strobe_t strb,
  output logic        busy,
  output logic        done,
  output logic        eraseOk,
  output logic        errOverrun,
  output logic        errBitUp,
  output logic        errNotErased
);

  localparam logic [EW-1:0] EQ_LAST = EW'(EQ_CYCLES - 1);

  seq_state_t state;
  logic [EW-1:0] eqCnt;
  logic accept;

  assign busy   = (state != S_IDLE);
  assign accept = (state == S_IDLE) && cmdValid && !abortReq;

  always_comb begin
    strb        = '0;
    strb.latch  = accept;
    strb.cntClr = accept;
    if (!abortReq) begin
      strb.cntInc = (state == S_CLR) || (state == S_SET);
      strb.wrZero = (state == S_CLR);
      strb.wrOne  = (state == S_SET);
      strb.wrProg = (state == S_PROG);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      eqCnt        <= '0;
      done         <= 1'b0;
      eraseOk      <= 1'b0;
      errOverrun   <= 1'b0;
      errBitUp     <= 1'b0;
      errNotErased <= 1'b0;
    end else if (abortReq) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      eraseOk <= 1'b0;
    end else begin
      if (busy && cmdValid) errOverrun <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (cmdValid) begin
            done         <= 1'b0;
            errOverrun   <= 1'b0;
            errBitUp     <= 1'b0;
            errNotErased <= 1'b0;
            if (!cmdProg) begin
              eraseOk <= 1'b0;
              state   <= S_CLR;
            end else if (!eraseOk) begin
              errNotErased <= 1'b1;
            end else if (!progLegal) begin
              errBitUp <= 1'b1;
            end else begin
              state <= S_PROG;
            end
          end
        end
        S_CLR: if (cntLast) state <= S_SET;
        S_SET: begin
          if (cntLast) begin
            state <= S_EQ;
            eqCnt <= '0;
          end
        end
        S_EQ: begin
          eqCnt <= eqCnt + 1'b1;
          if (eqCnt == EQ_LAST) begin
            state   <= S_IDLE;
            done    <= 1'b1;
            eraseOk <= 1'b1;
          end
        end
        S_PROG: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import flash_seq_pkg::*;
#(
  parameter int WORDS     = 64,
  parameter int DATA_W    = 32,
  parameter int EQ_CYCLES = 16,
  localparam int AW       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdProg,
  input  logic [AW-1:0]     cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              abortReq,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              eraseOk,
  output logic              errOverrun,
  output logic              errBitUp,
  output logic              errNotErased
);

  seq_strobe_t strb;
  logic cntLast;
  logic progLegal;

  flash_seq_ctrl #(.EQ_CYCLES(EQ_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdProg     (cmdProg),
    .abortReq    (abortReq),
    .cntLast     (cntLast),
    .progLegal   (progLegal),
    .strb        (strb),
    .busy        (busy),
    .done        (done),
    .eraseOk     (eraseOk),
    .errOverrun  (errOverrun),
    .errBitUp    (errBitUp),
    .errNotErased(errNotErased)
  );

  flash_seq_dpath #(.WORDS(WORDS), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .cntLast  (cntLast),
    .progLegal(progLegal)
  );

endmodule

// File: rtl/flash_bank_seq_chk.sv
module flash_bank_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdProg,
  input logic abortReq,
  input logic busy,
  input logic done,
  input logic eraseOk,
  input logic errOverrun,
  input logic errNotErased
);

  // R5: abort returns to idle without done or eraseOk
  p_abort_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!busy && !done && !eraseOk));

  // R2: eraseOk only rises at the end of a busy erase, together with done
  p_ok_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseOk) |-> (done && $past(busy)));

  // R2: done is never shown while an operation runs
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: a command during busy flags overrun
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid && !abortReq) |=> errOverrun);

  // R10: an operation never starts with eraseOk still high after an erase accept
  p_start_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && !cmdProg && !abortReq) |=> (busy && !eraseOk));

  // R6: program refused before a complete erase
  p_prog_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !eraseOk && cmdValid && cmdProg && !abortReq) |=> (!busy && errNotErased && !done));

endmodule

bind flash_bank_seq flash_bank_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdProg     (cmdProg),
  .abortReq    (abortReq),
  .busy        (busy),
  .done        (done),
  .eraseOk     (eraseOk),
  .errOverrun  (errOverrun),
  .errNotErased(errNotErased)
);

// File: tb/flash_bank_seq_tb.sv
module flash_bank_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 64;
  localparam int DATA_W     = 32;
  localparam int EQ_CYCLES  = 16;
  localparam int AW         = $clog2(WORDS);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdProg = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdData = '0;
  logic abortReq = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic busy, done, eraseOk, errOverrun, errBitUp, errNotErased;

  int nChecks = 0;
  int nFails = 0;
  logic [DATA_W-1:0] model [WORDS];

  // scoreboard queues
  logic [DATA_W-1:0] expQ [$];
  string tagQ [$];
  int addrQ [$];
  logic rdReq = 1'b0;
  logic rdPend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bank_seq #(.WORDS(WORDS), .DATA_W(DATA_W), .EQ_CYCLES(EQ_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdProg(cmdProg),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .abortReq(abortReq),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .done(done),
    .eraseOk(eraseOk), .errOverrun(errOverrun), .errBitUp(errBitUp),
    .errNotErased(errNotErased)
  );

  task automatic check(input logic ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after the address was driven
  always @(posedge clk) rdPend <= rdReq;
  always @(negedge clk) begin
    if (rdPend && expQ.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      int a;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = addrQ.pop_front();
      check(rdData === e, $sformatf("%s word %0d", t, a), rdData, e);
    end
  end

  // driver: pushes expected read values
  task automatic readAll(input string req);
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      rdAddr = AW'(i);
      rdReq = 1'b1;
      expQ.push_back(model[i]);
      tagQ.push_back(req);
      addrQ.push_back(i);
    end
    @(negedge clk);
    rdReq = 1'b0;
    @(negedge clk);
  endtask

  // drive a command for one cycle; returns on the negedge after acceptance
  task automatic issueCmd(input logic prog, input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdProg = prog;
    cmdAddr = AW'(addr);
    cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkFlag(input logic act, input logic exp, input string req);
    check(act === exp, req, DATA_W'(act), DATA_W'(exp));
  endtask

  // legal program: busy one cycle then done, stored value ANDed
  task automatic progWord(input int addr, input logic [DATA_W-1:0] data, input string req);
    issueCmd(1'b1, addr, data);
    checkFlag(busy, 1'b1, {req, " busy during program"});
    @(negedge clk);
    checkFlag(done, 1'b1, {req, " done after program"});
    model[addr] = model[addr] & data;
  endtask

  task automatic abortAfter(input int cycles);
    issueCmd(1'b0, 0, '0);
    for (int i = 0; i < cycles; i++) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = ONES;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkFlag(busy, 1'b0, "R1 busy");
    checkFlag(done, 1'b0, "R1 done");
    checkFlag(eraseOk, 1'b0, "R1 eraseOk");
    checkFlag(errOverrun | errBitUp | errNotErased, 1'b0, "R1 errors");
    readAll("R1");

    // R6 program before any erase
    issueCmd(1'b1, 5, 32'h0);
    checkFlag(errNotErased, 1'b1, "R6 errNotErased");
    checkFlag(busy, 1'b0, "R6 no busy");
    @(negedge clk);
    checkFlag(done, 1'b0, "R6 no done");
    readAll("R6");

    // R2 full erase, R10 eraseOk low while running, R9 overrun during it
    begin
      int cnt;
      issueCmd(1'b0, 0, '0);
      checkFlag(eraseOk, 1'b0, "R10 eraseOk low in erase");
      checkFlag(errNotErased, 1'b0, "R9 errors cleared by accepted erase");
      cnt = 0;
      while (busy && cnt < 1000) begin
        cnt++;
        cmdValid = (cnt == 10);
        cmdProg = 1'b1;
        cmdAddr = '0;
        cmdData = '0;
        @(negedge clk);
      end
      cmdValid = 1'b0;
      check(cnt == 2*WORDS + EQ_CYCLES, "R2 busy length", DATA_W'(cnt),
            DATA_W'(2*WORDS + EQ_CYCLES));
      checkFlag(done, 1'b1, "R2 done");
      checkFlag(eraseOk, 1'b1, "R2 eraseOk");
      checkFlag(errOverrun, 1'b1, "R9 overrun flagged");
    end
    for (int i = 0; i < WORDS; i++) model[i] = ONES;
    readAll("R2 R9 all ones");

    // R7 legal programs, R9 errors clear
    progWord(3, 32'hF0F0_1234, "R7");
    checkFlag(errOverrun, 1'b0, "R9 overrun cleared");
    progWord(3, 32'hF0F0_0234, "R7 reprogram");
    // R8 attempt to set bits back
    issueCmd(1'b1, 3, ONES);
    checkFlag(errBitUp, 1'b1, "R8 errBitUp");
    checkFlag(busy, 1'b0, "R8 no busy");
    @(negedge clk);
    checkFlag(done, 1'b0, "R8 no done");
    for (int i = 0; i < WORDS; i++)
      if (i != 3) progWord(i, 32'hA5C3_0000 ^ DATA_W'(i * 32'h0101_0111), "R7 fill");
    readAll("R7 R8");

    // R3 abort in phase 1 after 20 words; R11 read port through readAll
    abortAfter(20);
    checkFlag(busy, 1'b0, "R5 busy off after abort");
    checkFlag(done, 1'b0, "R5 no done after abort");
    checkFlag(eraseOk, 1'b0, "R5 eraseOk off after abort");
    for (int i = 0; i < 20; i++) model[i] = '0;
    readAll("R3 R11");

    // R4 abort in phase 2 after 10 words
    abortAfter(WORDS + 10);
    for (int i = 0; i < WORDS; i++) model[i] = (i < 10) ? ONES : '0;
    readAll("R4");

    // R5 abort during equalize
    abortAfter(2*WORDS + 5);
    checkFlag(eraseOk, 1'b0, "R5 eraseOk off after equalize abort");
    for (int i = 0; i < WORDS; i++) model[i] = ONES;
    readAll("R5");
    issueCmd(1'b1, 7, 32'h0);
    checkFlag(errNotErased, 1'b1, "R6 refused after aborted erase");
    readAll("R6 after abort");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule